// File: doc/BRIEF.md
# Transaction Order Recording Checker

This block sits beside a serial link and confirms that the link keeps the relative order of two kinds of request: writes and doorbell notifications. It watches two observation points, one where requests are handed to the link and one where they come out on the far side. At each point it appends a one-bit type code for every accepted request to a history register of its own, in the order the requests arrive.

When both histories hold the expected number of entries, or when an end-of-test strobe arrives, the block compares the two histories bit by bit and issues a single verdict. The verdict is a done flag plus a pass bit. A sticky mismatch flag stays raised until a start-of-test pulse clears the whole block for the next run.

Each observation point may accept a write and a doorbell in the same cycle. Each history stops recording when it is full and raises an overflow flag.

Top module: `order_track_chk`

## Requirements
- R1: After reset, and on the cycle after a `start_i` pulse, both fill counts are 0, and `done_o`, `pass_o`, `mismatch_o` and both overflow flags are 0.
- R2: Each accepted write appends the code 0 and each accepted doorbell appends the code 1 to that point's history, in arrival order. Each append raises the fill count by one.
- R3: When a write and a doorbell are accepted in the same cycle at one point, the write's 0 is appended before the doorbell's 1.
- R4: A doorbell accepted one cycle after a write is recorded after that write, so the sequences "write, then doorbell" on one side and "write plus doorbell in one cycle" on the other side compare equal.
- R5: The verdict passes only if the fill counts are equal and every history position matches. A single differing position fails it.
- R6: When both fill counts equal `EXPECT_CNT` in the same cycle, the verdict is issued one cycle later without any `eot_i`. It is not issued while only one count has reached `EXPECT_CNT`.
- R7: An `eot_i` pulse issues the verdict one cycle later. If the fill counts differ at that point, the verdict fails and `mismatch_o` rises.
- R8: `mismatch_o` stays at 1 until a `start_i` pulse.
- R9: Once a history holds `DEPTH` entries, further entries at that point are ignored. Its count stays at `DEPTH` and its overflow flag is set and held until `start_i`.
- R10: After `done_o` rises, `pass_o` is frozen until `start_i`, whatever is recorded later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-of-test pulse; clears histories, counts and verdict |
| pre_wr_i | input | 1 | A write accepted at the link entry this cycle |
| pre_db_i | input | 1 | A doorbell accepted at the link entry this cycle |
| post_wr_i | input | 1 | A write accepted at the link exit this cycle |
| post_db_i | input | 1 | A doorbell accepted at the link exit this cycle |
| eot_i | input | 1 | End-of-test strobe; forces the verdict |
| done_o | output | 1 | Verdict has been issued |
| pass_o | output | 1 | Verdict result, meaningful while done_o is 1 |
| mismatch_o | output | 1 | Sticky order-violation flag |
| pre_cnt_o | output | CNT_W | Entries recorded at the link entry |
| post_cnt_o | output | CNT_W | Entries recorded at the link exit |
| pre_ovf_o | output | 1 | Entry-side history overflowed |
| post_ovf_o | output | 1 | Exit-side history overflowed |

## Verification
The bench builds the block with `DEPTH` = 6 and `EXPECT_CNT` = 4. At that size, every pair of four-entry type sequences (256 pairs) can be swept through the automatic verdict path, with the expected result simply whether the two 4-bit codes are equal. The small depth also makes overflow reachable in a few cycles and leaves room above the expected count, so the end-of-test path, count disagreement and the frozen verdict can each be driven on purpose.

// File: rtl/otc_pkg.sv
package otc_pkg;

    // One-bit type code stored per history entry
    typedef enum logic {
        KIND_WRITE    = 1'b0,
        KIND_DOORBELL = 1'b1
    } txn_kind_e;

    // Requests accepted at one observation point in one cycle
    typedef struct packed {
        logic wr;
        logic db;
    } obs_t;

    // Registered verdict state
    typedef struct packed {
        logic done;
        logic pass;
        logic mismatch;
    } verdict_t;

    // Number of points observed (entry and exit of the link)
    localparam int NUM_POINTS = 2;

    function automatic int idx_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/otc_history.sv
module otc_history
    import otc_pkg::*;
#(
    parameter int DEPTH = 40,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  obs_t             obs,
    output logic [DEPTH-1:0] hist_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam int               IDX_W = idx_width(DEPTH);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(DEPTH);

    logic [DEPTH-1:0] hist_q, hist_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             ovf_q, ovf_n;

    // Write slot is taken first, doorbell slot second
    always_comb begin
        hist_n = hist_q;
        cnt_n  = cnt_q;
        ovf_n  = ovf_q;
        if (obs.wr) begin
            if (cnt_n < FULL) begin
                hist_n[cnt_n[IDX_W-1:0]] = KIND_WRITE;
                cnt_n = cnt_n + 1'b1;
            end else begin
                ovf_n = 1'b1;
            end
        end
        if (obs.db) begin
            if (cnt_n < FULL) begin
                hist_n[cnt_n[IDX_W-1:0]] = KIND_DOORBELL;
                cnt_n = cnt_n + 1'b1;
            end else begin
                ovf_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            hist_q <= hist_n;
            cnt_q  <= cnt_n;
            ovf_q  <= ovf_n;
        end
    end

    assign hist_o = hist_q;
    assign cnt_o  = cnt_q;
    assign ovf_o  = ovf_q;

endmodule

// File: rtl/otc_verdict.sv
module otc_verdict
    import otc_pkg::*;
#(
    parameter int DEPTH      = 40,
    parameter int CNT_W      = $clog2(DEPTH + 1),
    parameter int EXPECT_CNT = DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             eot,
    input  logic [DEPTH-1:0] hist_a,
    input  logic [DEPTH-1:0] hist_b,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    output verdict_t         verdict_o
);
    localparam logic [CNT_W-1:0] EXP = CNT_W'(EXPECT_CNT);

    logic [DEPTH-1:0] diff_bits;
    logic             same;
    logic             trigger;
    verdict_t         v_q;

    // Position-by-position comparison of the two histories
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign diff_bits[i] = hist_a[i] ^ hist_b[i];
    end

    assign same    = ~|diff_bits && (cnt_a == cnt_b);
    assign trigger = eot || ((cnt_a == EXP) && (cnt_b == EXP));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            v_q <= '0;
        end else if (trigger && !v_q.done) begin
            v_q.done     <= 1'b1;
            v_q.pass     <= same;
            v_q.mismatch <= v_q.mismatch | ~same;
        end
    end

    assign verdict_o = v_q;

endmodule

// File: rtl/order_track_chk.sv
module order_track_chk
    import otc_pkg::*;
#(
    parameter int DEPTH      = 40,
    parameter int EXPECT_CNT = DEPTH,
    parameter int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             pre_wr_i,
    input  logic             pre_db_i,
    input  logic             post_wr_i,
    input  logic             post_db_i,
    input  logic             eot_i,
    output logic             done_o,
    output logic             pass_o,
    output logic             mismatch_o,
    output logic [CNT_W-1:0] pre_cnt_o,
    output logic [CNT_W-1:0] post_cnt_o,
    output logic             pre_ovf_o,
    output logic             post_ovf_o
);
    obs_t             obs    [NUM_POINTS];
    logic [DEPTH-1:0] hist_w [NUM_POINTS];
    logic [CNT_W-1:0] cnt_w  [NUM_POINTS];
    logic             ovf_w  [NUM_POINTS];
    verdict_t         verdict;

    assign obs[0] = '{wr: pre_wr_i,  db: pre_db_i};
    assign obs[1] = '{wr: post_wr_i, db: post_db_i};

    for (genvar p = 0; p < NUM_POINTS; p++) begin : g_point
        otc_history #(
            .DEPTH (DEPTH),
            .CNT_W (CNT_W)
        ) u_hist (
            .clk    (clk),
            .rst    (rst),
            .clr    (start_i),
            .obs    (obs[p]),
            .hist_o (hist_w[p]),
            .cnt_o  (cnt_w[p]),
            .ovf_o  (ovf_w[p])
        );
    end

    otc_verdict #(
        .DEPTH      (DEPTH),
        .CNT_W      (CNT_W),
        .EXPECT_CNT (EXPECT_CNT)
    ) u_verdict (
        .clk       (clk),
        .rst       (rst),
        .clr       (start_i),
        .eot       (eot_i),
        .hist_a    (hist_w[0]),
        .hist_b    (hist_w[1]),
        .cnt_a     (cnt_w[0]),
        .cnt_b     (cnt_w[1]),
        .verdict_o (verdict)
    );

    assign done_o     = verdict.done;
    assign pass_o     = verdict.pass;
    assign mismatch_o = verdict.mismatch;
    assign pre_cnt_o  = cnt_w[0];
    assign post_cnt_o = cnt_w[1];
    assign pre_ovf_o  = ovf_w[0];
    assign post_ovf_o = ovf_w[1];

endmodule

// File: rtl/otc_chk.sv
module otc_chk #(
    parameter int DEPTH = 40,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             eot_i,
    input logic             done_o,
    input logic             pass_o,
    input logic             mismatch_o,
    input logic [CNT_W-1:0] pre_cnt_o,
    input logic [CNT_W-1:0] post_cnt_o,
    input logic             pre_ovf_o,
    input logic             post_ovf_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (pre_cnt_o == '0 && post_cnt_o == '0 && !done_o && !mismatch_o)); // R1

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (pre_cnt_o <= FULL) && (post_cnt_o <= FULL)); // R9

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pre_cnt_o == FULL && !start_i) |=> (pre_cnt_o == FULL)); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((pre_ovf_o || post_ovf_o) && !start_i) |=> (pre_ovf_o || post_ovf_o)); // R9

    AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
        (mismatch_o && !start_i) |=> mismatch_o); // R8

    AST_VERDICT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(pass_o))); // R10

    AST_EOT_VERDICT: assert property (@(posedge clk) disable iff (rst)
        (eot_i && !start_i) |=> done_o); // R7

    AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> (done_o && !mismatch_o)); // R5

endmodule

bind order_track_chk otc_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_otc_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .eot_i      (eot_i),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .mismatch_o (mismatch_o),
    .pre_cnt_o  (pre_cnt_o),
    .post_cnt_o (post_cnt_o),
    .pre_ovf_o  (pre_ovf_o),
    .post_ovf_o (post_ovf_o)
);

// File: tb/tb_order_track_chk.sv
module tb_order_track_chk;
    localparam int T_DEPTH = 6;
    localparam int T_EXP   = 4;
    localparam int T_CW    = $clog2(T_DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, eot_i = 1'b0;
    logic pre_wr_i = 1'b0, pre_db_i = 1'b0, post_wr_i = 1'b0, post_db_i = 1'b0;
    logic done_o, pass_o, mismatch_o, pre_ovf_o, post_ovf_o;
    logic [T_CW-1:0] pre_cnt_o, post_cnt_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    order_track_chk #(.DEPTH(T_DEPTH), .EXPECT_CNT(T_EXP)) dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .pre_wr_i(pre_wr_i), .pre_db_i(pre_db_i),
        .post_wr_i(post_wr_i), .post_db_i(post_db_i),
        .eot_i(eot_i), .done_o(done_o), .pass_o(pass_o), .mismatch_o(mismatch_o),
        .pre_cnt_o(pre_cnt_o), .post_cnt_o(post_cnt_o),
        .pre_ovf_o(pre_ovf_o), .post_ovf_o(post_ovf_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic pw, input logic pd, input logic qw, input logic qd);
        @(negedge clk);
        pre_wr_i = pw; pre_db_i = pd; post_wr_i = qw; post_db_i = qd;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk);
        pre_wr_i = 0; pre_db_i = 0; post_wr_i = 0; post_db_i = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic pulse_eot();
        @(negedge clk);
        eot_i = 1'b1;
        @(negedge clk);
        eot_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 pre_cnt", pre_cnt_o, 0);
        check("R1 post_cnt", post_cnt_o, 0);
        check("R1 done", done_o, 0);
        check("R1 pass", pass_o, 0);
        check("R1 mismatch", mismatch_o, 0);
        check("R1 ovf", pre_ovf_o | post_ovf_o, 0);

        // R2 R5 R6: exhaustive sweep of 4-entry codes, bit=1 means doorbell
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                restart();
                for (int i = 0; i < T_EXP; i++)
                    drive(~a[i], a[i], ~b[i], b[i]);
                idle();
                check("R2 pre_cnt", pre_cnt_o, T_EXP);
                check("R6 auto verdict done", done_o, 1);
                check("R5 pass", pass_o, (a == b) ? 1 : 0);
                check("R5 mismatch", mismatch_o, (a != b) ? 1 : 0);
            end
        end

        // R3 R4: same-cycle pair vs one-cycle-apart write then doorbell
        restart();
        drive(1, 1, 1, 0);
        drive(0, 0, 0, 1);
        idle();
        check("R3 pre_cnt", pre_cnt_o, 2);
        check("R4 post_cnt", post_cnt_o, 2);
        check("R6 no early verdict", done_o, 0);
        pulse_eot();
        check("R4 pass", pass_o, 1);
        check("R3 done", done_o, 1);

        // R3: same-cycle pair is write first, so doorbell-then-write differs
        restart();
        drive(1, 1, 0, 1);
        drive(0, 0, 1, 0);
        idle();
        pulse_eot();
        check("R3 reversed pass", pass_o, 0);
        check("R3 reversed mismatch", mismatch_o, 1);

        // R7: count disagreement at end of test, prefix equal
        restart();
        drive(1, 0, 1, 0);
        drive(0, 1, 0, 1);
        drive(1, 0, 0, 0);
        idle();
        check("R7 no verdict yet", done_o, 0);
        pulse_eot();
        check("R7 done", done_o, 1);
        check("R7 pass", pass_o, 0);
        check("R7 mismatch", mismatch_o, 1);

        // R8: sticky until start
        repeat (5) @(negedge clk);
        check("R8 mismatch held", mismatch_o, 1);
        restart();
        check("R8 mismatch cleared", mismatch_o, 0);
        check("R1 done cleared", done_o, 0);

        // R9: overflow on entry side; pattern 0,1,1,0,1,0 then two extra doorbells
        restart();
        begin
            logic [7:0] pat;
            pat = 8'b1101_0110;
            for (int i = 0; i < 8; i++) drive(~pat[i], pat[i], 0, 0);
            idle();
            check("R9 pre_cnt held", pre_cnt_o, T_DEPTH);
            check("R9 pre_ovf", pre_ovf_o, 1);
            check("R9 post_ovf", post_ovf_o, 0);
            for (int i = 0; i < T_DEPTH; i++) drive(0, 0, ~pat[i], pat[i]);
            idle();
            check("R6 one side only", done_o, 0);
            pulse_eot();
            check("R9 extras ignored pass", pass_o, 1);
            check("R9 ovf still held", pre_ovf_o, 1);
        end

        // R10: verdict frozen after done
        restart();
        for (int i = 0; i < T_EXP; i++) drive(1, 0, 1, 0);
        idle();
        check("R10 first pass", pass_o, 1);
        drive(0, 1, 1, 0);
        idle();
        pulse_eot();
        check("R10 pass frozen", pass_o, 1);
        check("R10 mismatch unchanged", mismatch_o, 0);
        restart();
        check("R1 start clears ovf", pre_ovf_o, 0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule